// File: doc/BRIEF.md
# Indexed Vector Word Extract Unit

This block is the execute slice for one vector instruction. The instruction picks a four-byte field out of two 128-bit vector operands and places it in a 128-bit result. The two operands are joined into a 32-byte string. The first operand supplies the leading bytes and the second supplies the trailing bytes. Bytes are numbered from the most significant end, so byte 0 is the top byte of the first operand. The starting byte comes from the five least-significant bits of a 64-bit general-purpose register.

The chosen bytes go into the low half of the most-significant doubleword of the result. The rest of the result is zero. The unit decodes the 32-bit instruction word and acts only on the matching encoding. When the vector-enable status bit is clear, the unit raises a vector-unavailable strobe and produces no result. It also returns the physical target register number.

All outputs except the combinational decode flag are registered with one cycle of latency.

Top module: `vec_word_extract`

## Requirements
- R1: `dec_match` is high, in the same cycle, exactly when `instr[31:26]` equals 4 and `instr[5:0]` equals 28. The remaining bit fields have no effect on it.
- R2: An accepted instruction is one with `in_valid`, a match and `vec_en` all high. One cycle after it, `out_valid` is 1 and `out_unavail` is 0.
- R3: A matching instruction with `in_valid` high and `vec_en` low gives `out_unavail` = 1 and `out_valid` = 0 one cycle later.
- R4: A cycle with `in_valid` low, or with a non-matching `instr`, gives `out_valid` = 0 and `out_unavail` = 0 one cycle later.
- R5: The byte index is `gpr_idx[4:0]`. Bits 63:5 of `gpr_idx` do not change the result.
- R6: `out_result[95:64]` holds bytes index through index+3 of the string `{src_a, src_b}`, with the first byte most significant. Byte k of the string is `{src_a,src_b}[255-8k -: 8]`. `out_result[127:96]` is zero.
- R7: `out_result[63:0]` is always zero.
- R8: For an index of 29, 30 or 31, the string positions past byte 31 read as zero bytes and do not wrap around. For example, index 31 gives `{byte31, 24'h0}`.
- R9: `out_tgt` equals the target field `instr[25:21]` plus 32, as a 6-bit number, and is set alongside `out_valid`.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_unavail`, `out_tgt` and `out_result` on the next edge.
- R11: `out_valid` and `out_unavail` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word, bit 31 is the leading encoding bit |
| vec_en | input | 1 | Vector-enable status bit |
| src_a | input | 128 | First vector operand, bytes 0..15 of the string |
| src_b | input | 128 | Second vector operand, bytes 16..31 of the string |
| gpr_idx | input | 64 | General-purpose register holding the byte index |
| dec_match | output | 1 | Combinational: instruction word is the extract encoding |
| out_valid | output | 1 | Registered result strobe |
| out_result | output | 128 | Registered extracted result |
| out_tgt | output | 6 | Registered physical target register number |
| out_unavail | output | 1 | Registered vector-unavailable exception strobe |

## Verification
The result path and the exception path both respond to the same decoded instruction, and they can meet on consecutive cycles. The bench runs a disabled instruction and then an enabled one back-to-back, with no idle cycle between them. In that sequence each output cycle must show only the strobe of its own instruction, never both at once. The extraction is also pushed to the edges of the string: across the boundary between the two operands, at index 28, and at indices 29 to 31 where zero fill takes over. Every expected word is computed from a byte-wise model in the bench.

// File: rtl/vxu_pkg.sv
package vxu_pkg;

    localparam int INSTR_W    = 32;
    localparam int VEC_W      = 128;
    localparam int GPR_W      = 64;
    localparam int FIELD_W    = 5;
    localparam int REG_W      = FIELD_W + 1;
    localparam int SRC_BYTES  = 2 * VEC_W / 8;
    localparam int IDX_W      = $clog2(SRC_BYTES);
    localparam int PICK_BYTES = 4;
    localparam int PICK_W     = PICK_BYTES * 8;
    localparam int DW_W       = VEC_W / 2;

    localparam logic [5:0] PRIMARY_OP = 6'd4;
    localparam logic [5:0] EXT_OP     = 6'd28;
    localparam logic [REG_W-1:0] VSR_UPPER_BASE = REG_W'(32);

    // Instruction fields, leading encoding bit first.
    typedef struct packed {
        logic [5:0]         primary;
        logic [FIELD_W-1:0] tgt;
        logic [FIELD_W-1:0] opa;
        logic [FIELD_W-1:0] opb;
        logic [FIELD_W-1:0] idxreg;
        logic [5:0]         ext;
    } va_fields_t;

    typedef enum logic [1:0] {
        OUTC_NONE   = 2'd0,
        OUTC_RESULT = 2'd1,
        OUTC_FAULT  = 2'd2
    } outcome_e;

    typedef struct packed {
        logic             valid;
        logic             unavail;
        logic [REG_W-1:0] tgt;
        logic [VEC_W-1:0] data;
    } xres_t;

    function automatic logic is_extract(input va_fields_t f);
        return (f.primary == PRIMARY_OP) && (f.ext == EXT_OP);
    endfunction

    function automatic logic [REG_W-1:0] upper_reg(input logic [FIELD_W-1:0] fld);
        return VSR_UPPER_BASE + REG_W'(fld);
    endfunction

    function automatic outcome_e classify(input logic vld, input logic hit, input logic en);
        if (!(vld && hit)) return OUTC_NONE;
        if (!en)           return OUTC_FAULT;
        return OUTC_RESULT;
    endfunction

endpackage

// File: rtl/vxu_decode.sv
module vxu_decode
    import vxu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output va_fields_t         fields,
    output logic               match,
    output logic [REG_W-1:0]   tgt_phys
);
    always_comb begin
        fields   = va_fields_t'(instr);
        match    = is_extract(fields);
        tgt_phys = upper_reg(fields.tgt);
    end

    // R9: a physical target always lies in the upper half of the register file.
    always_comb begin
        p_tgt_upper_r9: assert (tgt_phys >= VSR_UPPER_BASE)
            else $error("target below upper half");
    end
endmodule

// File: rtl/vxu_extract.sv
module vxu_extract #(
    parameter int SRC_BYTES  = 32,
    parameter int PICK_BYTES = 4,
    parameter int IDX_W      = 5
) (
    input  logic [SRC_BYTES*8-1:0]  src,
    input  logic [IDX_W-1:0]        idx,
    output logic [PICK_BYTES*8-1:0] word
);
    localparam int POS_W = IDX_W + 2;

    // One byte lane per picked byte; lane 0 is the most significant.
    for (genvar j = 0; j < PICK_BYTES; j++) begin : g_lane
        logic [POS_W-1:0] pos;
        logic [7:0]       sel;
        always_comb begin
            pos = POS_W'(idx) + POS_W'(j);
            sel = 8'h00;
            for (int k = 0; k < SRC_BYTES; k++) begin
                if (pos == POS_W'(k)) sel = src[(SRC_BYTES-1-k)*8 +: 8];
            end
        end
        assign word[(PICK_BYTES-1-j)*8 +: 8] = sel;

        // R8: lanes past the last string byte read zero.
        always_comb begin
            p_zero_fill_r8: assert ((pos < POS_W'(SRC_BYTES)) || (sel == 8'h00))
                else $error("lane past end not zero");
        end
    end
endmodule

// File: rtl/vxu_pack.sv
module vxu_pack
    import vxu_pkg::*;
(
    input  logic [PICK_W-1:0] word,
    output logic [VEC_W-1:0]  result
);
    logic [DW_W-1:0] dw_hi;
    logic [DW_W-1:0] dw_lo;

    always_comb begin
        dw_hi  = DW_W'(word);
        dw_lo  = '0;
        result = {dw_hi, dw_lo};
    end
endmodule

// File: rtl/vec_word_extract.sv
module vec_word_extract
    import vxu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [31:0]        instr,
    input  logic               vec_en,
    input  logic [127:0]       src_a,
    input  logic [127:0]       src_b,
    input  logic [63:0]        gpr_idx,
    output logic               dec_match,
    output logic               out_valid,
    output logic [127:0]       out_result,
    output logic [5:0]         out_tgt,
    output logic               out_unavail
);
    va_fields_t          fields;
    logic [REG_W-1:0]    tgt_phys;
    logic [PICK_W-1:0]   word;
    logic [VEC_W-1:0]    packed_res;
    logic [IDX_W-1:0]    idx;
    outcome_e            outcome;
    xres_t               res_d;
    xres_t               res_q;

    vxu_decode u_dec (
        .instr    (instr),
        .fields   (fields),
        .match    (dec_match),
        .tgt_phys (tgt_phys)
    );

    assign idx = gpr_idx[IDX_W-1:0];

    vxu_extract #(
        .SRC_BYTES  (SRC_BYTES),
        .PICK_BYTES (PICK_BYTES),
        .IDX_W      (IDX_W)
    ) u_ext (
        .src  ({src_a, src_b}),
        .idx  (idx),
        .word (word)
    );

    vxu_pack u_pack (
        .word   (word),
        .result (packed_res)
    );

    always_comb begin
        outcome = classify(in_valid, dec_match, vec_en);
        res_d   = '0;
        unique case (outcome)
            OUTC_RESULT: begin
                res_d.valid = 1'b1;
                res_d.tgt   = tgt_phys;
                res_d.data  = packed_res;
            end
            OUTC_FAULT: begin
                res_d.unavail = 1'b1;
                res_d.tgt     = tgt_phys;
            end
            default: res_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign out_valid   = res_q.valid;
    assign out_unavail = res_q.unavail;
    assign out_tgt     = res_q.tgt;
    assign out_result  = res_q.data;

    p_result_follows_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec_match && vec_en) |=> (out_valid && !out_unavail))
        else $error("accepted instruction gave no result");

    p_fault_follows_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec_match && !vec_en) |=> (out_unavail && !out_valid))
        else $error("disabled instruction gave no exception");

    p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || !dec_match) |=> (!out_valid && !out_unavail))
        else $error("strobe without accepted instruction");

    p_low_dword_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_result[63:0] == 64'h0 && out_result[127:96] == 32'h0))
        else $error("zero fields of result not clear");

    p_reset_r10: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_unavail && out_result == '0))
        else $error("reset did not clear outputs");

    p_mutex_r11: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_unavail))
        else $error("result and exception together");
endmodule

// File: tb/sim_vec_word_extract.sv
module sim_vec_word_extract;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [31:0]  instr;
    logic         vec_en;
    logic [127:0] src_a;
    logic [127:0] src_b;
    logic [63:0]  gpr_idx;
    logic         dec_match;
    logic         out_valid;
    logic [127:0] out_result;
    logic [5:0]   out_tgt;
    logic         out_unavail;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_word_extract u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .vec_en(vec_en),
        .src_a(src_a), .src_b(src_b), .gpr_idx(gpr_idx), .dec_match(dec_match),
        .out_valid(out_valid), .out_result(out_result), .out_tgt(out_tgt),
        .out_unavail(out_unavail)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] t,
                                       input logic [4:0] a, input logic [4:0] b,
                                       input logic [4:0] r, input logic [5:0] xo);
        return {op, t, a, b, r, xo};
    endfunction

    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input logic [63:0] g);
        int base = int'(g[4:0]);
        logic [31:0] w = 32'h0;
        logic [7:0] by;
        for (int j = 0; j < 4; j++) begin
            int p = base + j;
            if (p > 31)      by = 8'h00;
            else if (p < 16) by = a[127 - 8*p -: 8];
            else             by = b[127 - 8*(p-16) -: 8];
            w = {w[23:0], by};
        end
        return {32'h0, w, 64'h0};
    endfunction

    // Drive one cycle at the falling edge, sample just after the next rising edge.
    task automatic issue(input bit v, input logic [31:0] ins, input bit en,
                         input logic [127:0] a, input logic [127:0] b,
                         input logic [63:0] g);
        @(negedge clk);
        in_valid = v; instr = ins; vec_en = en; src_a = a; src_b = b; gpr_idx = g;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0; instr = 32'h0; vec_en = 0;
    endtask

    localparam logic [127:0] PA = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    localparam logic [127:0] PB = 128'h10213243_54657687_98A9BACB_DCEDFE0F;

    task automatic t_reset();
        rst = 1; in_valid = 1; instr = mk(6'd4, 5'd3, 5'd0, 5'd0, 5'd0, 6'd28);
        vec_en = 1; src_a = PA; src_b = PB; gpr_idx = 64'd2;
        repeat (3) @(posedge clk);
        #1;
        chk(!out_valid && !out_unavail, "R10 strobes", {126'h0, out_valid, out_unavail}, 0);
        chk(out_result == 0 && out_tgt == 0, "R10 data", out_result, 0);
        @(negedge clk); rst = 0; in_valid = 0;
    endtask

    task automatic t_decode();
        @(negedge clk);
        in_valid = 0;
        instr = mk(6'd4, 5'd17, 5'd9, 5'd30, 5'd12, 6'd28); #1;
        chk(dec_match == 1, "R1 match", {127'h0, dec_match}, 1);
        instr = mk(6'd5, 5'd17, 5'd9, 5'd30, 5'd12, 6'd28); #1;
        chk(dec_match == 0, "R1 primary", {127'h0, dec_match}, 0);
        instr = mk(6'd4, 5'd17, 5'd9, 5'd30, 5'd12, 6'd29); #1;
        chk(dec_match == 0, "R1 ext", {127'h0, dec_match}, 0);
    endtask

    task automatic t_extract(input logic [63:0] g, input logic [4:0] t, input string req);
        logic [127:0] exp = model(PA, PB, g);
        issue(1, mk(6'd4, t, 5'd1, 5'd2, 5'd6, 6'd28), 1, PA, PB, g);
        chk(out_valid && !out_unavail, {req, " R2 strobe"},
            {126'h0, out_valid, out_unavail}, 128'h2);
        chk(out_result == exp, {req, " R6 data"}, out_result, exp);
        chk(out_result[63:0] == 64'h0, "R7 low dword", out_result, exp);
        chk(out_tgt == 6'(t) + 6'd32, "R9 target", {122'h0, out_tgt}, {122'h0, 6'(t) + 6'd32});
    endtask

    task automatic t_upper_bits();
        issue(1, mk(6'd4, 5'd0, 5'd1, 5'd2, 5'd6, 6'd28), 1, PA, PB, 64'hFFFF_FFFF_FFFF_FFE3);
        chk(out_result == model(PA, PB, 64'd3), "R5 upper gpr bits", out_result,
            model(PA, PB, 64'd3));
    endtask

    task automatic t_zero_fill();
        issue(1, mk(6'd4, 5'd2, 5'd1, 5'd2, 5'd6, 6'd28), 1, PA, PB, 64'd31);
        chk(out_result == {32'h0, 32'h0F000000, 64'h0}, "R8 index 31", out_result,
            {32'h0, 32'h0F000000, 64'h0});
        issue(1, mk(6'd4, 5'd2, 5'd1, 5'd2, 5'd6, 6'd28), 1, PA, PB, 64'd29);
        chk(out_result == {32'h0, 32'hEDFE0F00, 64'h0}, "R8 index 29", out_result,
            {32'h0, 32'hEDFE0F00, 64'h0});
    endtask

    task automatic t_fault_then_result();
        issue(1, mk(6'd4, 5'd8, 5'd1, 5'd2, 5'd6, 6'd28), 0, PA, PB, 64'd4);
        chk(out_unavail && !out_valid, "R3 fault", {126'h0, out_valid, out_unavail}, 128'h1);
        chk(!(out_valid && out_unavail), "R11 fault cycle", {126'h0, out_valid, out_unavail}, 1);
        issue(1, mk(6'd4, 5'd8, 5'd1, 5'd2, 5'd6, 6'd28), 1, PA, PB, 64'd4);
        chk(out_valid && !out_unavail, "R11 result after fault",
            {126'h0, out_valid, out_unavail}, 128'h2);
        chk(out_result == model(PA, PB, 64'd4), "R6 after fault", out_result,
            model(PA, PB, 64'd4));
    endtask

    task automatic t_ignored();
        issue(1, mk(6'd31, 5'd8, 5'd1, 5'd2, 5'd6, 6'd28), 1, PA, PB, 64'd4);
        chk(!out_valid && !out_unavail, "R4 wrong primary", {126'h0, out_valid, out_unavail}, 0);
        issue(1, mk(6'd4, 5'd8, 5'd1, 5'd2, 5'd6, 6'd12), 0, PA, PB, 64'd4);
        chk(!out_valid && !out_unavail, "R4 wrong ext", {126'h0, out_valid, out_unavail}, 0);
        issue(0, mk(6'd4, 5'd8, 5'd1, 5'd2, 5'd6, 6'd28), 1, PA, PB, 64'd4);
        chk(!out_valid && !out_unavail, "R4 no valid", {126'h0, out_valid, out_unavail}, 0);
    endtask

    initial begin
        t_reset();
        t_decode();
        t_extract(64'd0,  5'd1,  "idx0");
        t_extract(64'd5,  5'd31, "idx5");
        t_extract(64'd14, 5'd0,  "idx14 boundary");
        t_extract(64'd28, 5'd12, "idx28");
        t_upper_bits();
        t_zero_fill();
        t_fault_then_result();
        t_ignored();
        idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule